// File: doc/BRIEF.md
# Instruction Fetch Cache, Direct-Mapped

This block serves a 32-bit processor fetch port from a 4 KB direct-mapped store of opcodes. The store is indexed by the low 12 address bits, one entry per 32-bit word. Each word also keeps a tag, which is the low 24 bits of the address it was loaded from. A fetch is cached only when the top address byte is 0x00 or 0x80. Every other fetch, including the boot ROM window, goes as one read to a word-addressed memory port and is never stored.

On a miss, the whole 16-byte line that holds the requested word is loaded. This takes four sequential memory reads, from the lowest word of the line to the highest. The requested word goes back to the processor as soon as it arrives from memory. The fetch port stays closed until the whole line has been written.

An isolate input wipes every entry back to the all-ones (empty) pattern, one entry per cycle, and raises a busy flag while it runs. The same wipe runs after reset. If isolate arrives in the middle of a memory transaction, it is remembered and takes effect once that transaction ends.

Top module: `ifc_top`

## Requirements
- R1: After reset, `flush_busy` is high and `cpu_rdy` is low for 1026 cycles: two cycles of reset synchronization, then 1024 entry wipes. After that, every cached fetch misses.
- R2: An accepted cached fetch whose entry holds a matching tag pulses `cpu_rvalid` in the cycle after acceptance, with the stored word. It makes no memory read.
- R3: The tag covers only address bits 23:0. A fetch at 0x80xxxxxx therefore hits on a word loaded through 0x00xxxxxx with the same low 24 bits, and returns the stored word even if memory has changed.
- R4: A cached fetch whose entry holds a different tag misses and reloads the line. This evicts the previous line at that index.
- R5: A miss issues exactly four reads, at word addresses line_base+0, +1, +2 and +3 in that order, where `mem_addr` is the byte address shifted right by 2. `mem_valid` and `mem_addr` hold steady until `mem_ready`.
- R6: The requested word is returned in the cycle after its own memory handshake. At that point `cpu_rdy` is still low if later words of the line remain. `cpu_rdy` rises after the fourth handshake.
- R7: A fetch whose top address byte is neither 0x00 nor 0x80 makes one memory read at its own word address and returns that word. Repeating the fetch reads memory again.
- R8: Isolate seen while idle starts a 1024-cycle wipe. If a fetch request is present in the same cycle, isolate wins: `cpu_rdy` is low and the fetch is taken only after the wipe. No memory read happens during the wipe, and previously cached lines miss afterwards.
- R9: Isolate seen during a line fill or a bypass read does not cut the transaction short. The data is still returned, and the wipe starts right after the last handshake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cpu_req | input | 1 | Fetch request, held until accepted |
| cpu_addr | input | 32 | Fetch byte address |
| cpu_rdy | output | 1 | Fetch accepted at this edge when high together with `cpu_req` |
| cpu_rvalid | output | 1 | One-cycle pulse: `cpu_rdata` holds the opcode |
| cpu_rdata | output | 32 | Returned opcode |
| cache_isolate | input | 1 | Request to wipe the whole cache |
| flush_busy | output | 1 | Wipe in progress |
| mem_valid | output | 1 | Memory read request |
| mem_addr | output | 30 | Memory word address |
| mem_ready | input | 1 | Memory accepts the read; `mem_rdata` valid in this cycle |
| mem_rdata | input | 32 | Memory read data |

## Verification
The isolate input can land in the same cycle as two other events: the acceptance of a fetch, or a beat of a line fill that is in progress. To provoke the first, the bench raises isolate and a fetch of a line known to be cached together. It judges the result by `cpu_rdy` being low in that cycle, by the 1024-cycle wipe, by the absence of memory traffic during the wipe, and by the held fetch then missing against changed memory contents. To provoke the second, isolate is pulsed after the first handshake of a slow fill. The bench then checks that all four reads complete, that the right word is returned, that the wipe follows, and that a repeat of the fetch misses.

// File: rtl/ifc_pkg.sv
package ifc_pkg;
  typedef enum logic [1:0] {
    ST_WIPE   = 2'd0,
    ST_IDLE   = 2'd1,
    ST_FILL   = 2'd2,
    ST_DIRECT = 2'd3
  } ifc_state_e;
endpackage

// File: rtl/ifc_region.sv
module ifc_region #(
  parameter int          BANK_W  = 8,
  parameter int          NBANKS  = 2,
  parameter logic [15:0] BANK_LO = 16'h0000,
  parameter logic [15:0] BANK_HI = 16'h0080
) (
  input  logic [BANK_W-1:0] top_bits,
  output logic              cacheable
);
  logic [NBANKS-1:0] match;

  for (genvar g = 0; g < NBANKS; g++) begin : g_bank
    localparam logic [15:0] SEL = (g == 0) ? BANK_LO : BANK_HI;
    assign match[g] = (top_bits == SEL[BANK_W-1:0]);
  end

  assign cacheable = |match;
endmodule

// File: rtl/ifc_store.sv
module ifc_store #(
  parameter int ENTRIES = 1024,
  parameter int WIDX_W  = 10,
  parameter int TAG_W   = 24,
  parameter int DATA_W  = 32
) (
  input  logic              clk,
  input  logic              we,
  input  logic [WIDX_W-1:0] widx,
  input  logic [TAG_W-1:0]  wtag,
  input  logic [DATA_W-1:0] wdata,
  input  logic [WIDX_W-1:0] ridx,
  input  logic [TAG_W-1:0]  look_tag,
  output logic              hit,
  output logic [DATA_W-1:0] rdata
);
  logic [TAG_W-1:0]  tag_mem  [ENTRIES];
  logic [DATA_W-1:0] data_mem [ENTRIES];

  always_ff @(posedge clk) begin
    if (we) begin
      tag_mem[widx]  <= wtag;
      data_mem[widx] <= wdata;
    end
  end

  assign hit   = (tag_mem[ridx] == look_tag);
  assign rdata = data_mem[ridx];
endmodule

// File: rtl/ifc_ctrl.sv
module ifc_ctrl
  import ifc_pkg::*;
#(
  parameter int ENTRIES    = 1024,
  parameter int WIDX_W     = 10,
  parameter int TAG_W      = 24,
  parameter int DATA_W     = 32,
  parameter int MEM_AW     = 30,
  parameter int WORD_OFS   = 2,
  parameter int LINE_WORDS = 4,
  parameter int BEAT_W     = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic [MEM_AW-1:0] cpu_waddr,
  input  logic              cacheable,
  input  logic              hit,
  input  logic [DATA_W-1:0] st_rdata,
  input  logic              isolate,
  output logic              cpu_rdy,
  output logic              cpu_rvalid,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              flush_busy,
  output logic              mem_valid,
  output logic [MEM_AW-1:0] mem_addr,
  input  logic              mem_ready,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              st_we,
  output logic [WIDX_W-1:0] st_widx,
  output logic [TAG_W-1:0]  st_wtag,
  output logic [DATA_W-1:0] st_wdata
);
  ifc_state_e        state_q, state_d;
  logic [WIDX_W-1:0] wipe_q, wipe_d;
  logic [BEAT_W-1:0] beat_q, beat_d;
  logic [MEM_AW-1:0] req_q, req_d;
  logic              pend_q, pend_d;
  logic              rv_q, rv_d;
  logic [DATA_W-1:0] rd_q, rd_d;
  logic              pend_now;

  assign cpu_rdy    = (state_q == ST_IDLE) && !isolate;
  assign flush_busy = (state_q == ST_WIPE);
  assign cpu_rvalid = rv_q;
  assign cpu_rdata  = rd_q;
  assign pend_now   = pend_q | isolate;

  always_comb begin
    state_d   = state_q;
    wipe_d    = wipe_q;
    beat_d    = beat_q;
    req_d     = req_q;
    pend_d    = pend_q;
    rv_d      = 1'b0;
    rd_d      = rd_q;
    mem_valid = 1'b0;
    mem_addr  = '0;
    st_we     = 1'b0;
    st_widx   = wipe_q;
    st_wtag   = '1;
    st_wdata  = '1;
    case (state_q)
      ST_WIPE: begin
        st_we  = 1'b1;
        wipe_d = wipe_q + 1'b1;
        if (wipe_q == WIDX_W'(ENTRIES - 1)) state_d = ST_IDLE;
      end
      ST_IDLE: begin
        if (isolate) begin
          state_d = ST_WIPE;
          wipe_d  = '0;
        end else if (cpu_req) begin
          req_d = cpu_waddr;
          if (!cacheable) begin
            state_d = ST_DIRECT;
          end else if (hit) begin
            rv_d = 1'b1;
            rd_d = st_rdata;
          end else begin
            state_d = ST_FILL;
            beat_d  = '0;
          end
        end
      end
      ST_FILL: begin
        mem_valid = 1'b1;
        mem_addr  = {req_q[MEM_AW-1:BEAT_W], beat_q};
        pend_d    = pend_now;
        if (mem_ready) begin
          st_we    = 1'b1;
          st_widx  = {req_q[WIDX_W-1:BEAT_W], beat_q};
          st_wtag  = {req_q[TAG_W-WORD_OFS-1:BEAT_W], beat_q, {WORD_OFS{1'b0}}};
          st_wdata = mem_rdata;
          beat_d   = beat_q + 1'b1;
          if (beat_q == req_q[BEAT_W-1:0]) begin
            rv_d = 1'b1;
            rd_d = mem_rdata;
          end
          if (beat_q == BEAT_W'(LINE_WORDS - 1)) begin
            state_d = pend_now ? ST_WIPE : ST_IDLE;
            pend_d  = 1'b0;
            wipe_d  = '0;
          end
        end
      end
      ST_DIRECT: begin
        mem_valid = 1'b1;
        mem_addr  = req_q;
        pend_d    = pend_now;
        if (mem_ready) begin
          rv_d    = 1'b1;
          rd_d    = mem_rdata;
          state_d = pend_now ? ST_WIPE : ST_IDLE;
          pend_d  = 1'b0;
          wipe_d  = '0;
        end
      end
      default: state_d = ST_WIPE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_WIPE;
      wipe_q  <= '0;
      beat_q  <= '0;
      req_q   <= '0;
      pend_q  <= 1'b0;
      rv_q    <= 1'b0;
      rd_q    <= '0;
    end else begin
      state_q <= state_d;
      wipe_q  <= wipe_d;
      beat_q  <= beat_d;
      pend_q  <= pend_d;
      rv_q    <= rv_d;
      if (state_q == ST_IDLE && cpu_req && !isolate) req_q <= req_d;
      if (rv_d) rd_q <= rd_d;
    end
  end

  // R5: an unanswered memory read keeps its address
  p_mem_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr));

  // R5: a miss starts its fill at the first word of the line
  p_fill_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_req && cpu_rdy && cacheable && !hit |=> mem_valid && (mem_addr[BEAT_W-1:0] == '0));

  // R2: a hit answers next cycle without touching memory
  p_hit_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_req && cpu_rdy && cacheable && hit |=> cpu_rvalid && !mem_valid);

  // R6: every response follows a hit acceptance or a memory handshake
  p_rvalid_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rvalid |-> $past(cpu_req && cpu_rdy && cacheable && hit) || $past(mem_valid && mem_ready));

  // R7: a bypass fetch reads its own word
  p_direct_addr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_req && cpu_rdy && !cacheable |=> mem_valid && (mem_addr == $past(cpu_waddr)));

  // R8: isolate while idle starts the wipe and blocks fetches
  p_isolate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE) && isolate |=> flush_busy && !cpu_rdy && !mem_valid);
endmodule

// File: rtl/ifc_top.sv
module ifc_top #(
  parameter int          ADDR_W     = 32,
  parameter int          DATA_W     = 32,
  parameter int          INDEX_W    = 12,
  parameter int          TAG_W      = 24,
  parameter int          LINE_WORDS = 4,
  parameter int          BANK_W     = 8,
  parameter logic [15:0] BANK_LO    = 16'h0000,
  parameter logic [15:0] BANK_HI    = 16'h0080
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           cpu_req,
  input  logic [ADDR_W-1:0]              cpu_addr,
  output logic                           cpu_rdy,
  output logic                           cpu_rvalid,
  output logic [DATA_W-1:0]              cpu_rdata,
  input  logic                           cache_isolate,
  output logic                           flush_busy,
  output logic                           mem_valid,
  output logic [ADDR_W-$clog2(DATA_W/8)-1:0] mem_addr,
  input  logic                           mem_ready,
  input  logic [DATA_W-1:0]              mem_rdata
);
  localparam int WORD_OFS = $clog2(DATA_W / 8);
  localparam int WIDX_W   = INDEX_W - WORD_OFS;
  localparam int ENTRIES  = 1 << WIDX_W;
  localparam int BEAT_W   = $clog2(LINE_WORDS);
  localparam int MEM_AW   = ADDR_W - WORD_OFS;

  logic [1:0]        rst_sync;
  logic              rst_int_n;
  logic              cacheable, hit, st_we;
  logic [DATA_W-1:0] st_rdata, st_wdata;
  logic [WIDX_W-1:0] st_widx;
  logic [TAG_W-1:0]  st_wtag;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  ifc_region #(.BANK_W(BANK_W), .NBANKS(2), .BANK_LO(BANK_LO), .BANK_HI(BANK_HI)) u_region (
    .top_bits  (cpu_addr[ADDR_W-1:ADDR_W-BANK_W]),
    .cacheable (cacheable)
  );

  ifc_store #(.ENTRIES(ENTRIES), .WIDX_W(WIDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_store (
    .clk      (clk),
    .we       (st_we),
    .widx     (st_widx),
    .wtag     (st_wtag),
    .wdata    (st_wdata),
    .ridx     (cpu_addr[INDEX_W-1:WORD_OFS]),
    .look_tag (cpu_addr[TAG_W-1:0]),
    .hit      (hit),
    .rdata    (st_rdata)
  );

  ifc_ctrl #(
    .ENTRIES(ENTRIES), .WIDX_W(WIDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W), .MEM_AW(MEM_AW),
    .WORD_OFS(WORD_OFS), .LINE_WORDS(LINE_WORDS), .BEAT_W(BEAT_W)
  ) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .cpu_req    (cpu_req),
    .cpu_waddr  (cpu_addr[ADDR_W-1:WORD_OFS]),
    .cacheable  (cacheable),
    .hit        (hit),
    .st_rdata   (st_rdata),
    .isolate    (cache_isolate),
    .cpu_rdy    (cpu_rdy),
    .cpu_rvalid (cpu_rvalid),
    .cpu_rdata  (cpu_rdata),
    .flush_busy (flush_busy),
    .mem_valid  (mem_valid),
    .mem_addr   (mem_addr),
    .mem_ready  (mem_ready),
    .mem_rdata  (mem_rdata),
    .st_we      (st_we),
    .st_widx    (st_widx),
    .st_wtag    (st_wtag),
    .st_wdata   (st_wdata)
  );
endmodule

// File: tb/sim_ifc_top.sv
module sim_ifc_top;
  localparam int ENTRIES = 1024;

  typedef struct packed {
    logic [31:0] addr;
    logic [31:0] src;
    logic [7:0]  salt;
    logic [7:0]  lat;
    logic [7:0]  nrd;
    logic [7:0]  esalt;
    logic [7:0]  rq;
  } vec_t;

  // addr, source of expected word, memory salt, memory latency, reads, salt of expected word, requirement
  localparam vec_t VEC [12] = '{
    '{32'h0000_0100, 32'h0000_0100, 8'd0, 8'd1, 8'd4, 8'd0, 8'd5}, // R5 cold miss
    '{32'h0000_0104, 32'h0000_0104, 8'd0, 8'd0, 8'd0, 8'd0, 8'd2}, // R2 hit
    '{32'h0000_010C, 32'h0000_010C, 8'd0, 8'd2, 8'd0, 8'd0, 8'd2}, // R2 hit
    '{32'h8000_0108, 32'h0000_0108, 8'd1, 8'd0, 8'd0, 8'd0, 8'd3}, // R3 alias bank hit, stale
    '{32'h0000_1104, 32'h0000_1104, 8'd1, 8'd1, 8'd4, 8'd1, 8'd4}, // R4 conflict
    '{32'h0000_0100, 32'h0000_0100, 8'd1, 8'd0, 8'd4, 8'd1, 8'd4}, // R4 evicted line reloads
    '{32'hBFC0_0010, 32'hBFC0_0010, 8'd1, 8'd2, 8'd1, 8'd1, 8'd7}, // R7 boot region
    '{32'hBFC0_0010, 32'hBFC0_0010, 8'd2, 8'd0, 8'd1, 8'd2, 8'd7}, // R7 not kept
    '{32'h0000_0104, 32'h0000_0104, 8'd2, 8'd0, 8'd0, 8'd1, 8'd2}, // R2 kept line
    '{32'h1F80_0000, 32'h1F80_0000, 8'd2, 8'd1, 8'd1, 8'd2, 8'd7}, // R7 other region
    '{32'h8000_0FFC, 32'h8000_0FFC, 8'd2, 8'd3, 8'd4, 8'd2, 8'd5}, // R5 last index
    '{32'h8000_0FF0, 32'h8000_0FF0, 8'd2, 8'd0, 8'd0, 8'd2, 8'd2}  // R2 same line
  };

  logic        clk, rst_n, cpu_req, cpu_rdy, cpu_rvalid, cache_isolate, flush_busy;
  logic        mem_valid, mem_ready;
  logic [31:0] cpu_addr, cpu_rdata, mem_rdata;
  logic [29:0] mem_addr;
  logic [7:0]  salt, mem_lat;
  int          wcnt, hs_cnt, nchk, nfail, cyc;
  logic [29:0] logbuf [8];

  ifc_top u0 (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_addr(cpu_addr), .cpu_rdy(cpu_rdy),
    .cpu_rvalid(cpu_rvalid), .cpu_rdata(cpu_rdata), .cache_isolate(cache_isolate),
    .flush_busy(flush_busy), .mem_valid(mem_valid), .mem_addr(mem_addr),
    .mem_ready(mem_ready), .mem_rdata(mem_rdata)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [31:0] memw(input logic [29:0] wa, input logic [7:0] s);
    return ({wa, 2'b00} * 32'h9E37_79B1) ^ {s, 24'h00_0000};
  endfunction

  assign mem_ready = mem_valid && (wcnt >= int'(mem_lat));
  assign mem_rdata = memw(mem_addr, salt);

  always @(posedge clk) begin
    if (mem_valid && mem_ready) begin
      logbuf[hs_cnt % 8] <= mem_addr;
      hs_cnt <= hs_cnt + 1;
      wcnt   <= 0;
    end else if (mem_valid) wcnt <= wcnt + 1;
    else wcnt <= 0;
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      nfail = nfail + 1;
      $display("FAIL watchdog expired act=%0d exp=<150000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    nchk = nchk + 1;
    if (act !== exp) begin
      nfail = nfail + 1;
      $display("FAIL %s act=%h exp=%h", r, act, exp);
    end
  endtask

  task automatic fetch(input logic [31:0] a, output logic [31:0] d, output int reads);
    int r0;
    r0 = hs_cnt;
    cpu_req  = 1'b1;
    cpu_addr = a;
    while (!cpu_rdy) @(negedge clk);
    @(negedge clk);
    cpu_req = 1'b0;
    while (!cpu_rvalid) @(negedge clk);
    d = cpu_rdata;
    while (!cpu_rdy) @(negedge clk);
    reads = hs_cnt - r0;
  endtask

  initial begin
    logic [31:0] d;
    int          n, r0;
    nchk = 0; nfail = 0; cyc = 0; hs_cnt = 0; wcnt = 0;
    salt = 8'd0; mem_lat = 8'd0;
    cpu_req = 1'b0; cpu_addr = '0; cache_isolate = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 busy in reset", 32'(flush_busy), 32'd1);
    chk("R1 rdy in reset", 32'(cpu_rdy), 32'd0);
    chk("R1 rvalid in reset", 32'(cpu_rvalid), 32'd0);
    rst_n = 1'b1;
    n = 0;
    while (flush_busy) begin @(negedge clk); n++; end
    chk("R1 wipe length", 32'(n), 32'(ENTRIES + 2));
    chk("R1 no reads during wipe", 32'(hs_cnt), 32'd0);

    for (int i = 0; i < 12; i++) begin
      int rd;
      salt    = VEC[i].salt;
      mem_lat = VEC[i].lat;
      fetch(VEC[i].addr, d, rd);
      chk($sformatf("R%0d vec %0d data", VEC[i].rq, i), d, memw(VEC[i].src[31:2], VEC[i].esalt));
      chk($sformatf("R%0d vec %0d reads", VEC[i].rq, i), 32'(rd), 32'(VEC[i].nrd));
    end

    // R5 order and R6 forwarding: word 2 of a line with slow memory
    salt = 8'd3; mem_lat = 8'd2;
    r0 = hs_cnt;
    cpu_req = 1'b1; cpu_addr = 32'h0000_3008;
    @(negedge clk);
    cpu_req = 1'b0;
    while (!cpu_rvalid) @(negedge clk);
    chk("R6 forwarded data", cpu_rdata, memw(30'h0C02, 8'd3));
    chk("R6 reads at forward", 32'(hs_cnt - r0), 32'd3);
    chk("R6 port closed mid fill", 32'(cpu_rdy), 32'd0);
    while (!cpu_rdy) @(negedge clk);
    chk("R5 fill reads", 32'(hs_cnt - r0), 32'd4);
    for (int k = 0; k < 4; k++)
      chk($sformatf("R5 fill order beat %0d", k), 32'(logbuf[(r0 + k) % 8]), 32'(30'h0C00 + k));

    // R8 isolate and fetch together
    salt = 8'd4; mem_lat = 8'd0;
    r0 = hs_cnt;
    cache_isolate = 1'b1; cpu_req = 1'b1; cpu_addr = 32'h0000_3008;
    #1;
    chk("R8 isolate wins", 32'(cpu_rdy), 32'd0);
    @(negedge clk);
    cache_isolate = 1'b0;
    chk("R8 busy raised", 32'(flush_busy), 32'd1);
    n = 0;
    while (flush_busy) begin @(negedge clk); n++; end
    chk("R8 wipe length", 32'(n), 32'(ENTRIES));
    chk("R8 no reads in wipe", 32'(hs_cnt - r0), 32'd0);
    while (!cpu_rdy) @(negedge clk);
    @(negedge clk);
    cpu_req = 1'b0;
    while (!cpu_rvalid) @(negedge clk);
    chk("R8 held fetch refilled", cpu_rdata, memw(30'h0C02, 8'd4));
    while (!cpu_rdy) @(negedge clk);
    chk("R8 line was wiped", 32'(hs_cnt - r0), 32'd4);

    // R9 isolate during a fill
    salt = 8'd5; mem_lat = 8'd3;
    r0 = hs_cnt;
    cpu_req = 1'b1; cpu_addr = 32'h0000_5004;
    @(negedge clk);
    cpu_req = 1'b0;
    while (hs_cnt == r0) @(negedge clk);
    cache_isolate = 1'b1;
    @(negedge clk);
    cache_isolate = 1'b0;
    while (!cpu_rvalid) @(negedge clk);
    chk("R9 data despite isolate", cpu_rdata, memw(30'h1401, 8'd5));
    n = 0;
    while (!flush_busy && n < 40) begin @(negedge clk); n++; end
    chk("R9 wipe follows fill", 32'(flush_busy), 32'd1);
    chk("R9 fill completed", 32'(hs_cnt - r0), 32'd4);
    while (flush_busy) @(negedge clk);
    begin
      int rd;
      fetch(32'h0000_5004, d, rd);
      chk("R9 line wiped after fill", 32'(rd), 32'd4);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule